// File: doc/BRIEF.md
# Soft-Stepping Stereo Volume Stage

This block scales a stereo stream of signed 16-bit audio samples by a programmable attenuation. The attenuation is a 7-bit code n, which stands for -n/2 dB, so 0 is unity gain and 127 is -63.5 dB. Each channel has its own target register and its own mute input. One master write loads the same code into both targets.

The gain actually applied does not jump to a new target. It walks one code toward the target on each accepted sample, or on every second sample when the slow-rate input is high. Mute and power-down both act as an extra code, 128, that sits below the lowest step. When a channel's ramp reaches 128, its output is exactly zero. A ramp-off input bypasses the walk, and the applied code then follows the target directly.

Two flags report progress to the host. `settled` shows that both applied codes have reached their targets. `pdn_done` shows that a power-down request has finished its fade to silence.

Top module: `softstep_volume`

## Requirements
- R1: Synchronous reset sets both targets and applied codes to 0. It drives `out_l`, `out_r` and `out_valid` to 0, `settled` to 1 and `pdn_done` to 0.
- R2: One cycle after a cycle with `sample_valid` high, `out_valid` is 1 and each output equals floor((s*G + 16384) / 32768). Here s is the sample, c is the applied code before that sample's step, and G = round(32768 * 10^(-(c mod 12)/40)) shifted right by floor(c/12). Without `sample_valid` the outputs hold.
- R3: A cycle with `vol_wr_all` loads `vol_code` into both targets. `vol_wr_l` or `vol_wr_r` loads it into that channel's target only.
- R4: With `ramp_off` low, an applied code moves by exactly one toward its effective target on an accepted sample. It never moves in a cycle without `sample_valid`.
- R5: With `slow_rate` high, only every second sample may step. Samples alternate between non-stepping and stepping, counted from reset over every sample, so the first sample after reset does not step.
- R6: `settled` is 1 exactly when both applied codes equal their effective targets. A target write that differs from the applied code clears it in the next cycle.
- R7: A high mute input makes that channel's effective target 128. The applied code ramps down to 128, where the output is exactly 0. The other channel is unaffected, and releasing mute ramps the code back toward the target.
- R8: With `ramp_off` high, the applied code equals the effective target one cycle later, whether or not samples arrive.
- R9: `pdn_req` makes 128 the effective target of both channels. `pdn_done` is 1 exactly when `pdn_req` is high and both applied codes are 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A new sample pair is present |
| sample_l | input | 16 | Left input sample, signed |
| sample_r | input | 16 | Right input sample, signed |
| vol_code | input | 7 | Attenuation code for writes, -n/2 dB |
| vol_wr_l | input | 1 | Load `vol_code` into the left target |
| vol_wr_r | input | 1 | Load `vol_code` into the right target |
| vol_wr_all | input | 1 | Load `vol_code` into both targets |
| mute_l | input | 1 | Mute the left channel |
| mute_r | input | 1 | Mute the right channel |
| slow_rate | input | 1 | Step on every second sample only |
| ramp_off | input | 1 | Skip the ramp and jump to the target |
| pdn_req | input | 1 | Fade both channels to silence |
| out_valid | output | 1 | Output samples were updated this cycle |
| out_l | output | 16 | Left scaled sample, signed |
| out_r | output | 16 | Right scaled sample, signed |
| settled | output | 1 | Both applied codes equal their targets |
| pdn_done | output | 1 | Power-down fade complete |

## Verification
The hardest condition to reach from the ports is the interaction of the slow rate with a power-down fade. Whether a given sample steps depends on the parity of every sample since reset, including samples taken while the ramp was bypassed. The fade to 128 can also start from any applied code. The stimulus drives long sample trains through ramp-off jumps, slow ramps, one-channel mute and a full power-down fade. A reference model tracks the sample parity and both applied codes from reset, so `settled`, `pdn_done` and every output are compared after each cycle.

// File: rtl/svol_pkg.sv
package svol_pkg;

    // Half-dB codes per 6 dB (one right shift of the gain).
    localparam int OCT_STEPS = 12;
    // Fraction bits of the unsigned gain word; 1.0 = 2**GAIN_FRAC.
    localparam int GAIN_FRAC = 15;

    typedef struct packed {
        logic slow;     // step on every other sample
        logic bypass;   // jump directly to target
    } ramp_cfg_t;

    // Gain mantissa for k half-dB steps inside one octave,
    // round(32768 * 10^(-k/40)).
    function automatic logic [GAIN_FRAC+1:0] oct_mant(input logic [3:0] k);
        logic [GAIN_FRAC+1:0] m;
        case (k)
            4'd0:    m = 17'd32768;
            4'd1:    m = 17'd30935;
            4'd2:    m = 17'd29205;
            4'd3:    m = 17'd27571;
            4'd4:    m = 17'd26029;
            4'd5:    m = 17'd24573;
            4'd6:    m = 17'd23198;
            4'd7:    m = 17'd21900;
            4'd8:    m = 17'd20675;
            4'd9:    m = 17'd19519;
            4'd10:   m = 17'd18427;
            default: m = 17'd17396;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/svol_ramp.sv
module svol_ramp #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          jump,
    input  logic [AW-1:0] eff,
    output logic [AW-1:0] applied
);

    always_ff @(posedge clk) begin
        if (rst) begin
            applied <= '0;
        end else if (jump) begin
            applied <= eff;
        end else if (step_en && (applied != eff)) begin
            if (applied < eff) applied <= applied + AW'(1);
            else               applied <= applied - AW'(1);
        end
    end

    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(jump)) |->
            (applied == $past(applied) ||
             applied == $past(applied) + AW'(1) ||
             applied == $past(applied) - AW'(1)));

    // R4
    no_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(jump) && !$past(step_en)) |-> $stable(applied));

    // R8
    jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(jump)) |-> (applied == $past(eff)));

endmodule

// File: rtl/svol_gain.sv
module svol_gain
    import svol_pkg::*;
#(
    parameter int SW = 16,
    parameter int AW = 8
) (
    input  logic signed [SW-1:0] sample,
    input  logic        [AW-1:0] code,
    output logic signed [SW-1:0] scaled
);

    localparam int PW = SW + GAIN_FRAC + 3;
    localparam logic [AW-1:0] MUTE_CODE = AW'(1 << (AW - 1));

    logic [3:0]             frac_idx;
    logic [3:0]             oct;
    logic [GAIN_FRAC+1:0]   gain;
    logic signed [GAIN_FRAC+2:0] gain_s;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   rnd;

    always_comb begin
        frac_idx = 4'(code % AW'(OCT_STEPS));
        oct      = 4'(code / AW'(OCT_STEPS));
        gain     = oct_mant(frac_idx) >> oct;
        gain_s   = $signed({1'b0, gain});
        prod     = sample * gain_s;
        rnd      = prod + PW'(1 << (GAIN_FRAC - 1));
        if (code >= MUTE_CODE) scaled = '0;
        else                   scaled = SW'(rnd >>> GAIN_FRAC);
    end

endmodule

// File: rtl/softstep_volume.sv
module softstep_volume
    import svol_pkg::*;
#(
    parameter int SW = 16,
    parameter int CW = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_valid,
    input  logic signed [SW-1:0] sample_l,
    input  logic signed [SW-1:0] sample_r,
    input  logic        [CW-1:0] vol_code,
    input  logic                 vol_wr_l,
    input  logic                 vol_wr_r,
    input  logic                 vol_wr_all,
    input  logic                 mute_l,
    input  logic                 mute_r,
    input  logic                 slow_rate,
    input  logic                 ramp_off,
    input  logic                 pdn_req,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_l,
    output logic signed [SW-1:0] out_r,
    output logic                 settled,
    output logic                 pdn_done
);

    localparam int NCH = 2;
    localparam int AW  = CW + 1;
    localparam logic [AW-1:0] MUTE_CODE = AW'(1 << CW);

    ramp_cfg_t cfg;
    logic      phase;
    logic      step_en;
    logic [NCH-1:0] wr, mute;
    logic signed [SW-1:0] smp    [NCH];
    logic signed [SW-1:0] scaled [NCH];
    logic signed [SW-1:0] out_q  [NCH];
    logic [CW-1:0] tgt     [NCH];
    logic [AW-1:0] eff     [NCH];
    logic [AW-1:0] applied [NCH];
    logic [NCH-1:0] at_tgt, at_mute;

    assign cfg     = '{slow: slow_rate, bypass: ramp_off};
    assign step_en = sample_valid && (!cfg.slow || phase);
    assign wr      = {vol_wr_r | vol_wr_all, vol_wr_l | vol_wr_all};
    assign mute    = {mute_r, mute_l};
    assign smp[0]  = sample_l;
    assign smp[1]  = sample_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= sample_valid;
            if (sample_valid) phase <= !phase;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                tgt[ch]   <= '0;
                out_q[ch] <= '0;
            end else begin
                if (wr[ch])       tgt[ch]   <= vol_code;
                if (sample_valid) out_q[ch] <= scaled[ch];
            end
        end

        assign eff[ch]     = (mute[ch] || pdn_req) ? MUTE_CODE : {1'b0, tgt[ch]};
        assign at_tgt[ch]  = (applied[ch] == eff[ch]);
        assign at_mute[ch] = (applied[ch] == MUTE_CODE);

        svol_ramp #(.AW(AW)) i_ramp (
            .clk     (clk),
            .rst     (rst),
            .step_en (step_en),
            .jump    (cfg.bypass),
            .eff     (eff[ch]),
            .applied (applied[ch])
        );

        svol_gain #(.SW(SW), .AW(AW)) i_gain (
            .sample (smp[ch]),
            .code   (applied[ch]),
            .scaled (scaled[ch])
        );

        // R7
        mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(sample_valid) && $past(applied[ch]) == MUTE_CODE)
                |-> (out_q[ch] == '0));

        // R2
        out_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(sample_valid)) |-> $stable(out_q[ch]));
    end

    assign out_l    = out_q[0];
    assign out_r    = out_q[1];
    assign settled  = &at_tgt;
    assign pdn_done = pdn_req && (&at_mute);

    // R9
    pdn_settled_chk: assert property (@(posedge clk) disable iff (rst)
        pdn_done |-> (settled && eff[0] == MUTE_CODE && eff[1] == MUTE_CODE));

endmodule

// File: tb/test_softstep_volume.sv
module test_softstep_volume;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic sample_valid = 1'b0;
    logic signed [15:0] sample_l = '0, sample_r = '0;
    logic [6:0] vol_code = '0;
    logic vol_wr_l = 0, vol_wr_r = 0, vol_wr_all = 0;
    logic mute_l = 0, mute_r = 0, slow_rate = 0, ramp_off = 0, pdn_req = 0;
    logic out_valid, settled, pdn_done;
    logic signed [15:0] out_l, out_r;

    softstep_volume i_softstep_volume (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .sample_l(sample_l), .sample_r(sample_r), .vol_code(vol_code),
        .vol_wr_l(vol_wr_l), .vol_wr_r(vol_wr_r), .vol_wr_all(vol_wr_all),
        .mute_l(mute_l), .mute_r(mute_r), .slow_rate(slow_rate),
        .ramp_off(ramp_off), .pdn_req(pdn_req), .out_valid(out_valid),
        .out_l(out_l), .out_r(out_r), .settled(settled), .pdn_done(pdn_done)
    );

    localparam int NV = 10;
    localparam int VCODE [NV] = '{0, 1, 6, 11, 12, 23, 40, 64, 100, 127};
    localparam int VSMP  [NV] = '{12345, -20001, 32767, -32767, 1000,
                                  -7, 30000, -16384, 32767, 32767};

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int m_tgt [2], m_app [2], m_out [2];
    bit m_ph, m_ov;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_out(int s, int c);
        int g;
        longint p;
        if (c >= 128) return 0;
        g = int'($floor(32768.0 * $pow(10.0, -(c % 12) / 40.0) + 0.5)) >>> (c / 12);
        p = longint'(s) * longint'(g) + 64'sd16384;
        return int'(p >>> 15);
    endfunction

    function automatic int m_eff(int ch);
        if (pdn_req || (ch == 0 ? mute_l : mute_r)) return 128;
        return m_tgt[ch];
    endfunction

    task automatic tick();
        int e;
        int s [2];
        bit w [2];
        s[0] = int'(sample_l); s[1] = int'(sample_r);
        w[0] = vol_wr_l || vol_wr_all; w[1] = vol_wr_r || vol_wr_all;
        if (rst) begin
            m_tgt = '{0, 0}; m_app = '{0, 0}; m_out = '{0, 0};
            m_ph = 0; m_ov = 0;
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                e = m_eff(ch);
                if (sample_valid) m_out[ch] = exp_out(s[ch], m_app[ch]);
                if (ramp_off) m_app[ch] = e;
                else if (sample_valid && (!slow_rate || m_ph) && m_app[ch] != e)
                    m_app[ch] += (m_app[ch] < e) ? 1 : -1;
                if (w[ch]) m_tgt[ch] = int'(vol_code);
            end
            m_ov = sample_valid;
            if (sample_valid) m_ph = !m_ph;
        end
        @(posedge clk); #1;
    endtask

    task automatic cmp(string rq);
        chk({rq, " out_l"}, int'(out_l), m_out[0]);
        chk({rq, " out_r"}, int'(out_r), m_out[1]);
        chk({rq, " out_valid"}, int'(out_valid), int'(m_ov));
        chk({rq, " settled"}, int'(settled),
            int'(m_app[0] == m_eff(0) && m_app[1] == m_eff(1)));
        chk({rq, " pdn_done"}, int'(pdn_done),
            int'(pdn_req && m_app[0] == 128 && m_app[1] == 128));
    endtask

    task automatic samp(int l, int r, string rq);
        sample_l = 16'(l); sample_r = 16'(r); sample_valid = 1;
        tick();
        sample_valid = 0;
        cmp(rq);
    endtask

    task automatic write(int code, bit l, bit r, bit all);
        vol_code = 7'(code); vol_wr_l = l; vol_wr_r = r; vol_wr_all = all;
        tick();
        vol_wr_l = 0; vol_wr_r = 0; vol_wr_all = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        chk("R1 out_l", int'(out_l), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 settled", int'(settled), 1);
        chk("R1 pdn_done", int'(pdn_done), 0);

        // R2 / R3 / R8: gain vectors with ramp bypassed, master write
        ramp_off = 1;
        for (int i = 0; i < NV; i++) begin
            write(VCODE[i], 0, 0, 1);
            tick();
            chk("R8 settled after jump", int'(settled), 1);
            samp(VSMP[i], -VSMP[i], "R2");
            chk("R2 vector left", int'(out_l), exp_out(VSMP[i], VCODE[i]));
            chk("R3 master right", int'(out_r), exp_out(-VSMP[i], VCODE[i]));
        end
        // R2 extremes
        write(0, 0, 0, 1); tick();
        samp(-32768, 32767, "R2 unity");
        chk("R2 unity min", int'(out_l), -32768);
        chk("R2 unity max", int'(out_r), 32767);
        tick();
        chk("R2 hold", int'(out_l), -32768);

        // R3 / R4 / R6: left-only write, ramp one step per sample
        ramp_off = 0;
        write(6, 1, 0, 0);
        cmp("R6 clear on write");
        chk("R6 settled low", int'(settled), 0);
        repeat (3) begin tick(); cmp("R4 no sample"); end
        for (int k = 0; k < 8; k++) samp(20000, 20000, "R4 ramp");
        chk("R3 right unchanged", int'(out_r), 20000);
        chk("R4 left at 6", int'(out_l), exp_out(20000, 6));

        // R5 slow ramp back to 0
        slow_rate = 1;
        write(0, 1, 0, 0);
        for (int k = 0; k < 14; k++) samp(-25000, 9000, "R5 slow");
        chk("R5 settled", int'(settled), 1);
        slow_rate = 0;

        // R7 mute left from a deep code
        ramp_off = 1; write(120, 0, 0, 1); tick(); ramp_off = 0;
        mute_l = 1;
        for (int k = 0; k < 10; k++) samp(32767, 32767, "R7 mute");
        chk("R7 left zero", int'(out_l), 0);
        chk("R7 right live", int'(out_r), exp_out(32767, 120));
        mute_l = 0;
        for (int k = 0; k < 10; k++) samp(32767, 32767, "R7 unmute");

        // R9 power-down fade from mixed codes, slow rate
        write(3, 1, 0, 0);
        for (int k = 0; k < 5; k++) samp(1000, 1000, "R9 prep");
        pdn_req = 1; slow_rate = 1;
        tick(); cmp("R9 start");
        for (int k = 0; k < 300; k++) samp(30000, -30000, "R9 fade");
        chk("R9 done", int'(pdn_done), 1);
        chk("R9 left zero", int'(out_l), 0);
        chk("R9 right zero", int'(out_r), 0);
        pdn_req = 0;
        tick(); cmp("R9 release");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule